// File: doc/BRIEF.md
# Burst Memory Responder with Traffic Profiling

This block answers incrementing bursts from a DMA master on an AXI4 read and write channel pair. The data is 32 bits wide, one word per beat, and the storage is an internal memory addressed in words. Only one burst is in flight at a time. Before each data beat the responder waits a fixed number of access cycles. This stands in for a slow backing store, so the master sees realistic spacing between beats. If a read request and a write request arrive in the same cycle, the read is taken first.

Alongside the data path, four 32-bit statistics counters run free:

- total elapsed cycles, which includes the modelled access cycles;
- elapsed time in nanoseconds;
- bytes read;
- bytes written.

A profiling layer can clear all four together with a synchronous pulse, run a workload and then read the totals directly from the output ports. All counters wrap modulo 2^32.

Top module: `axi_burst_mem_prof`

## Requirements
- R1: After reset, all four counters read 0 and ar_ready, aw_ready, r_valid, w_ready and b_valid are low.
- R2: For each accepted request, ar_ready (for a read) or aw_ready (for a write) is high for exactly one cycle, and it is low again in the following cycle.
- R3: A burst has ar_len+1 (or aw_len+1) beats. Read beat i returns the word at index (ar_addr + i) modulo MEM_WORDS. r_last is high only on the final beat. r_resp is 2'b00 (OKAY) and r_id is 0 on every beat.
- R4: While r_ready is low, r_valid stays high and r_data stays stable. After every accepted read beat, r_valid is low in the next cycle.
- R5: Between an address handshake and the first data beat, and between two consecutive beats, the data valid/ready output (r_valid or w_ready) is low for exactly ACCESS_LAT+1 cycles.
- R6: During a write, w_ready is high for each beat, and w_data is stored at index (aw_addr + i) modulo MEM_WORDS when w_valid is seen. After the last beat, b_valid is raised with b_resp 2'b00 and b_id 0, and it is held until b_ready.
- R7: When ar_valid and aw_valid are both high in an idle cycle, the read is accepted first and aw_ready stays low until the read burst is over.
- R8: stat_cycles advances by 1 on every clock. On each accepted data beat, read or write, it advances by a further ACCESS_LAT.
- R9: stat_time advances by CYC_NS for each unit that stat_cycles advances, so stat_time always equals stat_cycles*CYC_NS modulo 2^32.
- R10: On the handshake of a burst's final beat, stat_rd_bytes (for a read) or stat_wr_bytes (for a write) grows by 4*(len+1). The byte counters change at no other time.
- R11: A high stat_clr zeroes all four counters at the next clock edge. This overrides any increment due in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_clr | input | 1 | Synchronous clear of the statistics counters |
| ar_valid | input | 1 | Read request valid |
| ar_ready | output | 1 | Read request accepted |
| ar_addr | input | ADDR_W | Read start word index |
| ar_len | input | LEN_W | Read beats minus one |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Master accepts read data |
| r_data | output | 32 | Read data word |
| r_resp | output | 2 | Read response, always OKAY |
| r_id | output | ID_W | Read ID, always 0 |
| r_last | output | 1 | Final read beat |
| aw_valid | input | 1 | Write request valid |
| aw_ready | output | 1 | Write request accepted |
| aw_addr | input | ADDR_W | Write start word index |
| aw_len | input | LEN_W | Write beats minus one |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Responder accepts write data |
| w_data | input | 32 | Write data word |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Master accepts write response |
| b_resp | output | 2 | Write response, always OKAY |
| b_id | output | ID_W | Write ID, always 0 |
| stat_cycles | output | 32 | Elapsed cycle count |
| stat_time | output | 32 | Elapsed time in ns |
| stat_rd_bytes | output | 32 | Bytes delivered by read bursts |
| stat_wr_bytes | output | 32 | Bytes absorbed by write bursts |

## Verification
The assertions check on every cycle the behaviours that are local in time:

- the one-cycle address ready pulse;
- the stable, held read beat under back-pressure and the gap after each accepted beat;
- a write response held until taken;
- that only one data-side handshake is active at a time;
- the fixed ratio between the time and cycle counters;
- that the byte counters stay put outside final-beat handshakes, and that a clear zeroes them.

The bench scenarios are needed for what depends on a whole burst: correct data at the correct wrapped address, r_last placement, the exact ACCESS_LAT+1 gap, the per-beat latency added to the cycle counter, the byte totals, read-first arbitration, and a clear that lands on a final beat.

// File: rtl/axi_burst_mem_prof.sv
module axi_burst_mem_prof #(
  parameter int MEM_WORDS  = 256,
  parameter int LEN_W      = 8,
  parameter int ID_W       = 4,
  parameter int ACCESS_LAT = 3,
  parameter int CYC_NS     = 4,
  localparam int ADDR_W    = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_clr,
  input  logic              ar_valid,
  output logic              ar_ready,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [LEN_W-1:0]  ar_len,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [31:0]       r_data,
  output logic [1:0]        r_resp,
  output logic [ID_W-1:0]   r_id,
  output logic              r_last,
  input  logic              aw_valid,
  output logic              aw_ready,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [LEN_W-1:0]  aw_len,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic [31:0]       w_data,
  output logic              b_valid,
  input  logic              b_ready,
  output logic [1:0]        b_resp,
  output logic [ID_W-1:0]   b_id,
  output logic [31:0]       stat_cycles,
  output logic [31:0]       stat_time,
  output logic [31:0]       stat_rd_bytes,
  output logic [31:0]       stat_wr_bytes
);

  localparam int LAT_W = $clog2(ACCESS_LAT + 2);
  localparam logic [LAT_W-1:0] LAT_LOAD = LAT_W'(ACCESS_LAT);
  localparam logic [31:0] STEP_CYC  = 32'd1;
  localparam logic [31:0] BEAT_CYC  = 32'(ACCESS_LAT + 1);
  localparam logic [31:0] STEP_TIME = 32'(CYC_NS);
  localparam logic [31:0] BEAT_TIME = 32'(CYC_NS * (ACCESS_LAT + 1));

  typedef enum logic [2:0] {
    S_IDLE, S_RADDR, S_RWAIT, S_RBEAT, S_WADDR, S_WWAIT, S_WBEAT, S_WRESP
  } state_t;

  state_t             state;
  logic [ADDR_W-1:0]  ptr;
  logic [LEN_W-1:0]   left;
  logic [LEN_W-1:0]   len_q;
  logic [LAT_W-1:0]   lat_cnt;
  logic [31:0]        mem [MEM_WORDS];

  logic rd_fire, wr_fire, beat_fire, last_beat;
  logic [31:0] burst_bytes;

  assign ar_ready  = (state == S_RADDR);
  assign aw_ready  = (state == S_WADDR);
  assign r_valid   = (state == S_RBEAT);
  assign w_ready   = (state == S_WBEAT);
  assign b_valid   = (state == S_WRESP);
  assign last_beat = (left == '0);
  assign r_last    = r_valid && last_beat;
  assign r_data    = mem[ptr];
  assign r_resp    = 2'b00;
  assign b_resp    = 2'b00;
  assign r_id      = '0;
  assign b_id      = '0;

  assign rd_fire     = r_valid && r_ready;
  assign wr_fire     = w_ready && w_valid;
  assign beat_fire   = rd_fire || wr_fire;
  assign burst_bytes = (32'(len_q) + 32'd1) << 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ptr     <= '0;
      left    <= '0;
      len_q   <= '0;
      lat_cnt <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (ar_valid)      state <= S_RADDR;
          else if (aw_valid) state <= S_WADDR;
        end
        S_RADDR: begin
          ptr     <= ar_addr;
          left    <= ar_len;
          len_q   <= ar_len;
          lat_cnt <= LAT_LOAD;
          state   <= S_RWAIT;
        end
        S_WADDR: begin
          ptr     <= aw_addr;
          left    <= aw_len;
          len_q   <= aw_len;
          lat_cnt <= LAT_LOAD;
          state   <= S_WWAIT;
        end
        S_RWAIT, S_WWAIT: begin
          if (lat_cnt == '0) state <= (state == S_RWAIT) ? S_RBEAT : S_WBEAT;
          else lat_cnt <= lat_cnt - 1'b1;
        end
        S_RBEAT: begin
          if (r_ready) begin
            ptr <= ptr + 1'b1;
            if (last_beat) state <= S_IDLE;
            else begin
              left    <= left - 1'b1;
              lat_cnt <= LAT_LOAD;
              state   <= S_RWAIT;
            end
          end
        end
        S_WBEAT: begin
          if (w_valid) begin
            ptr <= ptr + 1'b1;
            if (last_beat) state <= S_WRESP;
            else begin
              left    <= left - 1'b1;
              lat_cnt <= LAT_LOAD;
              state   <= S_WWAIT;
            end
          end
        end
        S_WRESP: if (b_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire) mem[ptr] <= w_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_cycles   <= '0;
      stat_time     <= '0;
      stat_rd_bytes <= '0;
      stat_wr_bytes <= '0;
    end else if (stat_clr) begin
      stat_cycles   <= '0;
      stat_time     <= '0;
      stat_rd_bytes <= '0;
      stat_wr_bytes <= '0;
    end else begin
      stat_cycles <= stat_cycles + (beat_fire ? BEAT_CYC : STEP_CYC);
      stat_time   <= stat_time + (beat_fire ? BEAT_TIME : STEP_TIME);
      if (rd_fire && last_beat) stat_rd_bytes <= stat_rd_bytes + burst_bytes;
      if (wr_fire && last_beat) stat_wr_bytes <= stat_wr_bytes + burst_bytes;
    end
  end

endmodule

module axi_burst_mem_prof_chk #(
  parameter int CYC_NS = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        stat_clr,
  input logic        ar_ready,
  input logic        aw_ready,
  input logic        r_valid,
  input logic        r_ready,
  input logic [31:0] r_data,
  input logic        r_last,
  input logic        w_ready,
  input logic        w_valid,
  input logic        b_valid,
  input logic        b_ready,
  input logic [31:0] stat_cycles,
  input logic [31:0] stat_time,
  input logic [31:0] stat_rd_bytes,
  input logic [31:0] stat_wr_bytes
);

  // R2
  addr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_ready || aw_ready) |=> !(ar_ready || aw_ready));

  // R4
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_last)));

  // R4
  r_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && r_ready) |=> !r_valid);

  // R6
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !b_ready) |=> b_valid);

  // R7
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ar_ready, aw_ready, r_valid, w_ready, b_valid}));

  // R9
  time_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_time == stat_cycles * 32'(CYC_NS));

  // R10
  rd_bytes_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_clr && !(r_valid && r_ready && r_last)) |=> $stable(stat_rd_bytes));

  // R10
  wr_bytes_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_clr && !(w_ready && w_valid)) |=> $stable(stat_wr_bytes));

  // R11
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> (stat_cycles == 0 && stat_rd_bytes == 0 && stat_wr_bytes == 0));

endmodule

bind axi_burst_mem_prof axi_burst_mem_prof_chk #(.CYC_NS(CYC_NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .stat_clr(stat_clr),
  .ar_ready(ar_ready), .aw_ready(aw_ready),
  .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_last(r_last),
  .w_ready(w_ready), .w_valid(w_valid), .b_valid(b_valid), .b_ready(b_ready),
  .stat_cycles(stat_cycles), .stat_time(stat_time),
  .stat_rd_bytes(stat_rd_bytes), .stat_wr_bytes(stat_wr_bytes)
);

// File: tb/axi_burst_mem_prof_bench.sv
module axi_burst_mem_prof_bench;
  localparam int MEM_WORDS = 256;
  localparam int LEN_W = 8;
  localparam int ID_W = 4;
  localparam int LAT = 3;
  localparam int CYC_NS = 4;
  localparam int ADDR_W = $clog2(MEM_WORDS);

  logic clk = 0, rst_n = 0, stat_clr = 0;
  logic ar_valid = 0, aw_valid = 0, r_ready = 0, w_valid = 0, b_ready = 0;
  logic [ADDR_W-1:0] ar_addr = '0, aw_addr = '0;
  logic [LEN_W-1:0] ar_len = '0, aw_len = '0;
  logic [31:0] w_data = '0;
  logic ar_ready, aw_ready, r_valid, r_last, w_ready, b_valid;
  logic [31:0] r_data;
  logic [1:0] r_resp, b_resp;
  logic [ID_W-1:0] r_id, b_id;
  logic [31:0] stat_cycles, stat_time, stat_rd_bytes, stat_wr_bytes;

  int ncheck = 0, nfail = 0;
  int unsigned pcount = 0;
  logic [31:0] model [MEM_WORDS];

  always #2 clk = ~clk;
  always @(posedge clk) pcount <= pcount + 1;

  axi_burst_mem_prof #(.MEM_WORDS(MEM_WORDS), .LEN_W(LEN_W), .ID_W(ID_W),
    .ACCESS_LAT(LAT), .CYC_NS(CYC_NS)) u_axi_burst_mem_prof (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    ncheck++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", ncheck, nfail);
  endtask

  task automatic wr_burst(input int addr, input int len, input int seed);
    int unsigned t0 = pcount;
    logic [31:0] c0 = stat_cycles, w0 = stat_wr_bytes;
    aw_valid = 1; aw_addr = ADDR_W'(addr); aw_len = LEN_W'(len);
    while (!aw_ready) @(negedge clk);
    @(negedge clk);
    aw_valid = 0;
    chk(!aw_ready, "R2", "aw_ready single cycle", aw_ready, 0);
    w_valid = 1;
    for (int i = 0; i <= len; i++) begin
      int gap = 0;
      int idx = (addr + i) % MEM_WORDS;
      w_data = 32'(seed) * 32'h01010101 + 32'(i * 7);
      while (!w_ready) begin gap++; @(negedge clk); end
      chk(gap == LAT + 1, "R5", "w_ready gap", gap, LAT + 1);
      model[idx] = w_data;
      @(negedge clk);
    end
    w_valid = 0;
    chk(stat_wr_bytes - w0 == 32'(4 * (len + 1)), "R10", "write bytes",
        stat_wr_bytes - w0, 4 * (len + 1));
    chk(stat_cycles - c0 == (pcount - t0) + 32'((len + 1) * LAT), "R8",
        "cycles over write", stat_cycles - c0, (pcount - t0) + (len + 1) * LAT);
    for (int k = 0; k < 2; k++) begin
      chk(b_valid, "R6", "b_valid held", b_valid, 1);
      @(negedge clk);
    end
    b_ready = 1;
    chk(b_valid && b_resp == 2'b00 && b_id == 0, "R6", "b response", {b_resp, b_id}, 0);
    @(negedge clk);
    b_ready = 0;
    chk(!b_valid, "R6", "b_valid dropped", b_valid, 0);
  endtask

  task automatic rd_burst(input int addr, input int len, input int stall, input bit clr_last);
    int unsigned t0 = pcount;
    logic [31:0] c0 = stat_cycles, r0 = stat_rd_bytes;
    ar_valid = 1; ar_addr = ADDR_W'(addr); ar_len = LEN_W'(len);
    while (!ar_ready && !aw_ready) @(negedge clk);
    chk(ar_ready && !aw_ready, "R7", "read accepted first", {ar_ready, aw_ready}, 2);
    @(negedge clk);
    ar_valid = 0;
    chk(!ar_ready, "R2", "ar_ready single cycle", ar_ready, 0);
    r_ready = (stall == 0);
    for (int i = 0; i <= len; i++) begin
      int gap = 0;
      int idx = (addr + i) % MEM_WORDS;
      while (!r_valid) begin gap++; @(negedge clk); end
      chk(gap == LAT + 1, "R5", "r_valid gap", gap, LAT + 1);
      for (int k = 0; k < stall; k++) begin
        logic [31:0] d = r_data;
        @(negedge clk);
        chk(r_valid && r_data == d, "R4", "beat held under stall", r_data, d);
      end
      r_ready = 1;
      chk(r_data == model[idx], "R3", "read data", r_data, model[idx]);
      chk(r_last == (i == len), "R3", "r_last", r_last, i == len);
      chk(r_resp == 2'b00 && r_id == 0, "R3", "r_resp/r_id", {r_resp, r_id}, 0);
      if (clr_last && i == len) stat_clr = 1;
      @(negedge clk);
      stat_clr = 0;
      r_ready = (stall == 0);
      chk(!r_valid, "R4", "r_valid low after beat", r_valid, 0);
    end
    r_ready = 0;
    if (clr_last) begin
      chk(stat_cycles == 0 && stat_time == 0, "R11", "clear overrides beat", stat_cycles, 0);
      chk(stat_rd_bytes == 0, "R11", "clear overrides byte add", stat_rd_bytes, 0);
    end else begin
      chk(stat_rd_bytes - r0 == 32'(4 * (len + 1)), "R10", "read bytes",
          stat_rd_bytes - r0, 4 * (len + 1));
      chk(stat_cycles - c0 == (pcount - t0) + 32'((len + 1) * LAT), "R8",
          "cycles over read", stat_cycles - c0, (pcount - t0) + (len + 1) * LAT);
      chk(stat_time == stat_cycles * CYC_NS, "R9", "time ratio", stat_time, stat_cycles * CYC_NS);
    end
  endtask

  task automatic t_reset();
    chk(stat_cycles == 0 && stat_time == 0, "R1", "timers after reset", stat_cycles, 0);
    chk(stat_rd_bytes == 0 && stat_wr_bytes == 0, "R1", "bytes after reset", stat_rd_bytes, 0);
    chk(!(ar_ready || aw_ready || r_valid || w_ready || b_valid), "R1", "handshakes idle",
        {ar_ready, aw_ready, r_valid, w_ready, b_valid}, 0);
  endtask

  task automatic t_idle_count();
    stat_clr = 1;
    @(negedge clk);
    stat_clr = 0;
    chk(stat_cycles == 0, "R11", "cycles cleared", stat_cycles, 0);
    repeat (10) @(negedge clk);
    chk(stat_cycles == 10, "R8", "idle cycles", stat_cycles, 10);
    chk(stat_time == 10 * CYC_NS, "R9", "idle time", stat_time, 10 * CYC_NS);
  endtask

  task automatic t_priority();
    aw_valid = 1; aw_addr = 8'd40; aw_len = '0;
    rd_burst(10, 1, 0, 0);
    wr_burst(40, 0, 9);
    rd_burst(40, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_idle_count();
    wr_burst(10, 4, 1);
    rd_burst(10, 4, 0, 0);
    rd_burst(10, 4, 3, 0);
    wr_burst(254, 3, 2);
    rd_burst(254, 3, 0, 0);
    wr_burst(100, 0, 5);
    rd_burst(100, 0, 1, 0);
    t_priority();
    rd_burst(10, 2, 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    ncheck++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule